// File: doc/BRIEF.md
# Correlating Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a short shift register of the most recent resolved branch outcomes across the whole program, and a table of small saturating counters. The table index combines low-order bits of the branch address with that global outcome history. The counter that is picked therefore depends on how neighbouring branches just went, not only on the branch itself. A build-time parameter chooses the index function. In concatenation mode every address row owns 2^HIST_W counters and the history selects among them. In XOR mode the history is folded onto the address row to form one shared index.

The fetch side presents a program counter on the lookup port. In the same cycle it receives a taken/not-taken guess and the table index that produced it. That index travels down the pipeline with the branch. When the branch resolves, the execute side returns the index and the real outcome on the update port. The addressed counter is then trained, and the outcome is shifted into the history. No tags are kept, so unrelated branches that share index bits share a counter.

Top module: `corr_bpred`

## Requirements
- R1: After reset the history holds zero and every counter holds the weakly-not-taken value 01, so every lookup predicts not-taken.
- R2: Each accepted update shifts its outcome into bit 0 of the history and drops the oldest bit. Lookups never change the history.
- R3: In concatenation mode `lk_idx` equals {row, history}, where row is `lk_pc[PC_LSB+ROW_W-1:PC_LSB]` (bits 5:2 by default) and the history occupies the low HIST_W bits.
- R4: In XOR mode `lk_idx` equals row XOR history, with the history zero-extended to ROW_W bits.
- R5: A counter counts up on a taken update and down on a not-taken update, saturating at 3 and at 0. The prediction is its upper bit, so a single opposite outcome from a saturated state leaves the prediction unchanged.
- R6: An update trains the counter at `up_idx` exactly as supplied, whatever the current history or lookup address.
- R7: When the lookup and the update address the same counter in one cycle, the lookup returns the value held before that update, and the update is seen from the next cycle.
- R8: Two addresses that differ only above the row bits get the same index and share one counter.
- R9: For a pair of branches where the second branch's outcome always equals the first branch's outcome, the second branch is predicted correctly on every iteration after warm-up.
- R10: In a cycle without an update, no counter and no history bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_pc | input | PC_W | Branch address to predict |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_idx | output | IDX_W | Table index used for this prediction, to be returned at update |
| up_valid | input | 1 | A resolved branch is presented this cycle |
| up_idx | input | IDX_W | Index captured at that branch's lookup |
| up_taken | input | 1 | Resolved direction, 1 = taken |

## Verification
A prediction and a training write can address the same counter in one cycle. The bench forces this by pointing the update index at the entry the current lookup address selects. It then checks that the guess in that cycle reflects the old count, and that a lookup of the same entry after the update reflects the new count. A cycle-accurate behavioural model, with its own arrays and an integer history, runs beside two instances, one per index mode. Across directed and random traffic it is compared with both instances on every clock.

// File: rtl/corr_bpred_pkg.sv
// Package: shared types for the correlating branch predictor.
package corr_bpred_pkg;

    // How history and address row are combined into a table index.
    typedef enum logic {
        IDX_CONCAT = 1'b0,
        IDX_XOR    = 1'b1
    } idx_mode_e;

endpackage

// File: rtl/bpred_ghr.sv
// Global history shift register.
// Shifts one resolved outcome into bit 0 whenever shift_en is high.
// Assumes HIST_W >= 1. Resets to all zeros.
module bpred_ghr #(
    parameter int HIST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              shift_bit,
    output logic [HIST_W-1:0] hist
);
    logic [HIST_W-1:0] hist_q;

    // Shift the newest outcome in and drop the oldest one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hist_q <= '0;
        else if (shift_en)
            hist_q <= HIST_W'({hist_q, shift_bit});
    end

    assign hist = hist_q;
endmodule

// File: rtl/bpred_index.sv
// Index former: combines an address row with the global history.
// CONCAT mode places the row above the history; XOR mode folds the history
// onto the row. XOR mode assumes ROW_W >= HIST_W.
module bpred_index #(
    parameter int                        ROW_W    = 4,
    parameter int                        HIST_W   = 2,
    parameter corr_bpred_pkg::idx_mode_e IDX_MODE = corr_bpred_pkg::IDX_CONCAT,
    parameter int                        IDX_W    = 6
) (
    input  logic [ROW_W-1:0]  row,
    input  logic [HIST_W-1:0] hist,
    output logic [IDX_W-1:0]  idx
);
    generate
        if (IDX_MODE == corr_bpred_pkg::IDX_CONCAT) begin : g_concat
            // Each row owns 2^HIST_W consecutive counters.
            assign idx = {row, hist};
        end else begin : g_xor
            logic [ROW_W-1:0] hist_ext;
            // Zero-extend the history, then fold it onto the row.
            assign hist_ext = ROW_W'(hist);
            assign idx      = row ^ hist_ext;
        end
    endgenerate
endmodule

// File: rtl/bpred_pht.sv
// Pattern table of CTR_W-bit saturating counters.
// One combinational read port and one write port. A read in the cycle of a
// write to the same entry returns the old value. Counters reset to weakly
// not-taken (the largest value whose upper bit is 0).
module bpred_pht #(
    parameter int IDX_W = 6,
    parameter int CTR_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    localparam int               DEPTH   = 1 << IDX_W;
    localparam logic [CTR_W-1:0] CTR_MAX = '1;
    localparam logic [CTR_W-1:0] CTR_RST = CTR_W'((1 << (CTR_W - 1)) - 1);

    logic [CTR_W-1:0] tbl_q [DEPTH];
    logic [CTR_W-1:0] wr_cur;
    logic [CTR_W-1:0] wr_nxt;

    // Saturating step of the counter being trained.
    always_comb begin
        wr_cur = tbl_q[wr_idx];
        if (wr_taken)
            wr_nxt = (wr_cur == CTR_MAX) ? wr_cur : wr_cur + 1'b1;
        else
            wr_nxt = (wr_cur == '0) ? wr_cur : wr_cur - 1'b1;
    end

    // Reset every counter, or write back the trained counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                tbl_q[i] <= CTR_RST;
        end else if (wr_en) begin
            tbl_q[wr_idx] <= wr_nxt;
        end
    end

    // The prediction is the counter's upper bit.
    assign rd_taken = tbl_q[rd_idx][CTR_W-1];
endmodule

// File: rtl/corr_bpred.sv
// Correlating branch direction predictor (top).
// The lookup returns a guess and the index that produced it. The update must
// return that same index with the resolved outcome. No tags are kept, so
// aliasing between branches is accepted.
module corr_bpred #(
    parameter int                        PC_W     = 32,
    parameter int                        PC_LSB   = 2,
    parameter int                        ROW_W    = 4,
    parameter int                        HIST_W   = 2,
    parameter int                        CTR_W    = 2,
    parameter corr_bpred_pkg::idx_mode_e IDX_MODE = corr_bpred_pkg::IDX_CONCAT,
    localparam int IDX_W = (IDX_MODE == corr_bpred_pkg::IDX_CONCAT) ? ROW_W + HIST_W : ROW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  lk_pc,
    output logic             lk_taken,
    output logic [IDX_W-1:0] lk_idx,
    input  logic             up_valid,
    input  logic [IDX_W-1:0] up_idx,
    input  logic             up_taken
);
    logic [HIST_W-1:0] ghr_q;
    logic [ROW_W-1:0]  lk_row;

    // Select the low-order address bits above the instruction alignment.
    assign lk_row = lk_pc[PC_LSB +: ROW_W];

    bpred_ghr #(.HIST_W(HIST_W)) u_ghr (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (up_valid),
        .shift_bit(up_taken),
        .hist     (ghr_q)
    );

    bpred_index #(
        .ROW_W   (ROW_W),
        .HIST_W  (HIST_W),
        .IDX_MODE(IDX_MODE),
        .IDX_W   (IDX_W)
    ) u_index (
        .row (lk_row),
        .hist(ghr_q),
        .idx (lk_idx)
    );

    bpred_pht #(.IDX_W(IDX_W), .CTR_W(CTR_W)) u_pht (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (lk_idx),
        .rd_taken(lk_taken),
        .wr_en   (up_valid),
        .wr_idx  (up_idx),
        .wr_taken(up_taken)
    );
endmodule

// File: rtl/corr_bpred_chk.sv
// Checker for corr_bpred: temporal properties on ports and history state.
// Bound into every corr_bpred instance.
module corr_bpred_chk #(
    parameter int PC_W   = 32,
    parameter int HIST_W = 2,
    parameter int IDX_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PC_W-1:0]   lk_pc,
    input logic              lk_taken,
    input logic [IDX_W-1:0]  lk_idx,
    input logic              up_valid,
    input logic [IDX_W-1:0]  up_idx,
    input logic              up_taken,
    input logic [HIST_W-1:0] hist
);
    // R2: an update shifts its outcome in at bit 0.
    a_r2_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid |=> hist == HIST_W'({$past(hist), $past(up_taken)}));

    // R10: without an update the history holds.
    a_r10_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |=> $stable(hist));

    // R10: without an update, the same address gets the same guess.
    a_r10_pred_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |=> (lk_pc != $past(lk_pc)) || (lk_taken == $past(lk_taken)));

    // R5: a taken update on a taken-predicting entry keeps it taken.
    a_r5_taken_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_taken && lk_idx == up_idx && lk_taken)
        |=> (lk_idx != $past(lk_idx)) || lk_taken);

    // R5: a not-taken update on a not-taken entry keeps it not-taken.
    a_r5_nt_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_taken && lk_idx == up_idx && !lk_taken)
        |=> (lk_idx != $past(lk_idx)) || !lk_taken);
endmodule

bind corr_bpred corr_bpred_chk #(
    .PC_W  (PC_W),
    .HIST_W(HIST_W),
    .IDX_W (IDX_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .lk_pc   (lk_pc),
    .lk_taken(lk_taken),
    .lk_idx  (lk_idx),
    .up_valid(up_valid),
    .up_idx  (up_idx),
    .up_taken(up_taken),
    .hist    (ghr_q)
);

// File: tb/corr_bpred_tb.sv
module corr_bpred_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        up_valid = 1'b0;
    logic        up_taken = 1'b0;
    logic [5:0]  up_idx_c = '0;
    logic [3:0]  up_idx_x = '0;
    logic        lk_taken_c, lk_taken_x;
    logic [5:0]  lk_idx_c;
    logic [3:0]  lk_idx_x;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // Reference model state
    int g;
    int tc [64];
    int tx [16];
    int last_tc, last_tx;

    always #5 clk = ~clk;

    corr_bpred u_dut (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken_c),
        .lk_idx(lk_idx_c), .up_valid(up_valid), .up_idx(up_idx_c), .up_taken(up_taken)
    );

    corr_bpred #(.IDX_MODE(corr_bpred_pkg::IDX_XOR)) u_dut_xor (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken_x),
        .lk_idx(lk_idx_x), .up_valid(up_valid), .up_idx(up_idx_x), .up_taken(up_taken)
    );

    function automatic int row_of(input logic [31:0] pc);
        return int'((pc >> 2) & 32'hF);
    endfunction
    function automatic int eic(input logic [31:0] pc);
        return (row_of(pc) << 2) | g;
    endfunction
    function automatic int eix(input logic [31:0] pc);
        return row_of(pc) ^ g;
    endfunction
    function automatic int sat(input int v, input bit t);
        if (t) return (v == 3) ? 3 : v + 1;
        return (v == 0) ? 0 : v - 1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock: drive, compare with model, advance the model after the edge.
    task automatic cyc(input logic [31:0] pc, input bit uv, input int uic,
                       input int uix, input bit ut, input string req);
        int ec, ex;
        lk_pc = pc; up_valid = uv; up_idx_c = 6'(uic); up_idx_x = 4'(uix); up_taken = ut;
        #2;
        ec = eic(pc); ex = eix(pc);
        chk(int'(lk_idx_c) == ec, {req, "/R3 concat idx"}, int'(lk_idx_c), ec);
        chk(int'(lk_idx_x) == ex, {req, "/R4 xor idx"}, int'(lk_idx_x), ex);
        chk(int'(lk_taken_c) == int'(tc[ec] >= 2), {req, " concat pred"}, int'(lk_taken_c), int'(tc[ec] >= 2));
        chk(int'(lk_taken_x) == int'(tx[ex] >= 2), {req, " xor pred"}, int'(lk_taken_x), int'(tx[ex] >= 2));
        last_tc = int'(lk_taken_c);
        last_tx = int'(lk_taken_x);
        @(posedge clk);
        #1;
        if (uv) begin
            tc[uic] = sat(tc[uic], ut);
            tx[uix] = sat(tx[uix], ut);
            g = ((g << 1) | int'(ut)) & 3;
        end
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int bim, bim_miss, b1, b2;
        g = 0;
        for (int i = 0; i < 64; i++) tc[i] = 1;
        for (int i = 0; i < 16; i++) tx[i] = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, every address predicts not-taken
        for (int p = 0; p < 16; p++) begin
            cyc(32'(p * 4), 0, 0, 0, 0, "R1");
            chk(last_tc == 0 && last_tx == 0, "R1 reset not-taken", last_tc, 0);
        end

        // R5/R6: train entry of pc 0x20 (concat 32, xor 8) with g=0
        for (int k = 0; k < 4; k++) cyc(32'h0, 1, 32, 8, 1, "R6");
        cyc(32'h0, 1, 0, 0, 0, "R6");
        cyc(32'h0, 1, 0, 0, 0, "R6");
        cyc(32'h20, 0, 0, 0, 0, "R5");
        chk(last_tc == 1 && last_tx == 1, "R5 saturated taken", last_tc, 1);
        cyc(32'h20, 1, 32, 8, 0, "R5");
        cyc(32'h20, 0, 0, 0, 0, "R5");
        chk(last_tc == 1 && last_tx == 1, "R5 one miss keeps taken", last_tc, 1);
        cyc(32'h20, 1, 32, 8, 0, "R5");
        cyc(32'h20, 0, 0, 0, 0, "R5");
        chk(last_tc == 0 && last_tx == 0, "R5 second miss flips", last_tc, 0);

        // R7: lookup and update hit the same entry (count 1) in one cycle
        cyc(32'h20, 1, 32, 8, 1, "R7");
        chk(last_tc == 0 && last_tx == 0, "R7 same-cycle sees old value", last_tc, 0);
        cyc(32'h0, 1, 0, 0, 0, "R7");
        cyc(32'h0, 1, 0, 0, 0, "R7");
        cyc(32'h20, 0, 0, 0, 0, "R7");
        chk(last_tc == 1 && last_tx == 1, "R7 update visible next", last_tc, 1);

        // R2/R3/R4: history 10b then 01b, pc 0x14 (row 5)
        cyc(32'h0, 1, 0, 0, 1, "R2");
        cyc(32'h0, 1, 0, 0, 0, "R2");
        cyc(32'h14, 0, 0, 0, 0, "R2");
        chk(lk_idx_c == 6'd22, "R3 idx {5,10b}", int'(lk_idx_c), 22);
        chk(lk_idx_x == 4'd7, "R4 idx 5^2", int'(lk_idx_x), 7);
        cyc(32'h0, 1, 0, 0, 1, "R2");
        cyc(32'h14, 0, 0, 0, 0, "R2");
        chk(lk_idx_c == 6'd21, "R2 history shifted to 01b", int'(lk_idx_c), 21);
        chk(lk_idx_x == 4'd4, "R4 idx 5^1", int'(lk_idx_x), 4);

        // R8: 0x20 and 0x60 share row 8
        cyc(32'h20, 0, 0, 0, 0, "R8");
        b1 = int'(lk_idx_c);
        cyc(32'h60, 0, 0, 0, 0, "R8");
        chk(int'(lk_idx_c) == b1, "R8 aliasing shares index", int'(lk_idx_c), b1);

        // R9: B1 at 0x100, B2 at 0x104; B2 outcome equals B1 outcome
        bim = 1; bim_miss = 0;
        for (int it = 0; it < 24; it++) begin
            b1 = it % 2;
            b2 = b1;
            cyc(32'h100, 1, eic(32'h100), eix(32'h100), b1[0], "R9");
            cyc(32'h104, 1, eic(32'h104), eix(32'h104), b2[0], "R9");
            if (it >= 8) begin
                chk(last_tc == b2, "R9 concat B2 perfect", last_tc, b2);
                chk(last_tx == b2, "R9 xor B2 perfect", last_tx, b2);
                if (int'(bim >= 2) != b2) bim_miss++;
            end
            bim = sat(bim, b2[0]);
        end
        chk(bim_miss > 0, "R9 plain counter would miss", bim_miss, 1);

        // R6/R10: random traffic with arbitrary (stale) indices
        for (int k = 0; k < 400; k++) begin
            automatic bit uv = 1'($urandom_range(0, 1));
            cyc($urandom & 32'hFF, uv, $urandom_range(0, 63), $urandom_range(0, 15),
                1'($urandom_range(0, 1)), uv ? "R6" : "R10");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule